// File: doc/BRIEF.md
# Floating-Point to Integer Converter

This block turns one IEEE-754 operand, either binary32 or binary64, into a signed or unsigned integer that is 32 or 64 bits wide. It handles the conversion steps of a scalar floating-point unit's float-to-integer operations. The rounding mode reaches the block already resolved. The block drops the fraction under that mode and checks the rounded value against the range of the chosen destination. A value that does not fit, an infinity, or a NaN is clamped to a fixed limit, and the invalid flag is raised.

Each conversion takes one cycle. The caller drives an operand with `inValid` high. One clock later `outValid` rises, together with a 64-bit integer and a 5-bit exception-flag vector. A 32-bit result is always sign-extended to the full 64 bits. This lets it drop straight into a 64-bit integer register.

Top module: `fp2int_cvt`

## Requirements
- R1: `outValid` is high exactly one cycle after a cycle with `inValid` high, and low otherwise. An active-low reset clears `outValid`, `result` and `flags` to zero.
- R2: `isDouble`=1 converts `operand[63:0]` as binary64. `isDouble`=0 converts `operand[31:0]` as binary32 and ignores `operand[63:32]`. `variant` selects the destination: 0 signed 32-bit, 1 unsigned 32-bit, 2 signed 64-bit, 3 unsigned 64-bit.
- R3: `rndMode` selects the rounding: 0 nearest with ties to even, 1 toward zero, 2 toward minus infinity, 3 toward plus infinity, 4 nearest with ties away from zero. Codes 5 to 7 behave as code 0.
- R4: An in-range result sets inexact (flag bit 0) exactly when the discarded fraction was nonzero. An exact result has all flags clear.
- R5: A NaN operand gives 0x7FFFFFFF for variant 0, 0x7FFFFFFFFFFFFFFF for variant 2, and all 64 ones for the unsigned variants. Only invalid (flag bit 4) is set.
- R6: For a signed variant, a rounded value above the destination maximum, or an infinity, saturates to the type's most positive value if positive and its most negative value if negative. Only invalid is set, never inexact.
- R7: For an unsigned variant with a negative operand, a value that rounds to zero gives 0. In that case only inexact is set, and only if the fraction was nonzero. A value that rounds below zero gives 0 with only invalid set.
- R8: For an unsigned variant, a positive value whose rounded magnitude exceeds the destination range, or plus infinity, gives all 64 bits one with only invalid set.
- R9: For variants 0 and 1, `result[63:32]` equals 32 copies of `result[31]`.
- R10: Flag bits 1 to 3 (underflow, overflow, divide-by-zero) are never set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operand and controls are valid this cycle |
| operand | input | 64 | Floating-point source bits |
| isDouble | input | 1 | 1 = binary64 source, 0 = binary32 in bits 31:0 |
| variant | input | 2 | Destination type select |
| rndMode | input | 3 | Resolved rounding mode |
| outValid | output | 1 | Result and flags valid |
| result | output | 64 | Integer result, sign-extended for 32-bit types |
| flags | output | 5 | Exception flags: bit 0 inexact, bit 4 invalid |

## Verification
The checker assumes two-state inputs that are stable across each rising edge. Its NaN and sign-based properties decode the operand with the same `isDouble` that is sampled in the capturing cycle. The bench changes every input only on the falling edge and keeps `inValid` low throughout reset, so each property sees exactly the operand that was converted. Every rounding code is fed well-formed operands. The reserved codes are covered by a separate directed vector instead of being left to chance.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  parameter int XLEN      = 64;
  parameter int HALF_W    = XLEN / 2;
  parameter int DP_EXP_W  = 11;
  parameter int DP_FRAC_W = 52;
  parameter int SP_EXP_W  = 8;
  parameter int SP_FRAC_W = 23;
  parameter int FLAG_W    = 5;

  localparam int MANT_W  = DP_FRAC_W + 1;
  localparam int EXP_W   = DP_EXP_W + 2;
  localparam int DP_BIAS = (1 << (DP_EXP_W - 1)) - 1;
  localparam int SP_BIAS = (1 << (SP_EXP_W - 1)) - 1;
  localparam int SP_PAD  = DP_FRAC_W - SP_FRAC_W;
  localparam int FX_W    = MANT_W + XLEN;
  localparam int MAG_W   = XLEN + 1;

  localparam int FLG_NX = 0;
  localparam int FLG_UF = 1;
  localparam int FLG_OF = 2;
  localparam int FLG_DZ = 3;
  localparam int FLG_NV = 4;

  typedef enum logic [2:0] {
    RM_NEAR_EVEN = 3'd0,
    RM_ZERO      = 3'd1,
    RM_DOWN      = 3'd2,
    RM_UP        = 3'd3,
    RM_NEAR_MAX  = 3'd4
  } rndSel_e;

  typedef enum logic [1:0] {
    DST_S32 = 2'd0,
    DST_U32 = 2'd1,
    DST_S64 = 2'd2,
    DST_U64 = 2'd3
  } dstSel_e;

  typedef struct packed {
    logic capture;
  } cvtStrobe_t;
endpackage

// File: rtl/f2i_ctrl.sv
module f2i_ctrl
  import f2i_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output cvtStrobe_t strobe,
  output logic       outValid
);
  always_comb strobe.capture = inValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/f2i_datapath.sv
module f2i_datapath
  import f2i_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cvtStrobe_t        strobe,
  input  logic [XLEN-1:0]   operand,
  input  logic              isDouble,
  input  logic [1:0]        variant,
  input  logic [2:0]        rndMode,
  output logic [XLEN-1:0]   result,
  output logic [FLAG_W-1:0] flags
);
  // unpacked source
  logic                    srcSign, srcNan, srcInf;
  logic signed [EXP_W-1:0] expUnb;
  logic [MANT_W-1:0]       mant;

  always_comb begin
    if (isDouble) begin
      srcSign = operand[XLEN-1];
      srcNan  = (&operand[62:52]) && (|operand[51:0]);
      srcInf  = (&operand[62:52]) && !(|operand[51:0]);
      mant    = {|operand[62:52], operand[51:0]};
      expUnb  = (operand[62:52] == '0) ? EXP_W'(1 - DP_BIAS)
              : $signed({2'b00, operand[62:52]}) - EXP_W'(DP_BIAS);
    end else begin
      srcSign = operand[31];
      srcNan  = (&operand[30:23]) && (|operand[22:0]);
      srcInf  = (&operand[30:23]) && !(|operand[22:0]);
      mant    = {|operand[30:23], operand[22:0], {SP_PAD{1'b0}}};
      expUnb  = (operand[30:23] == '0) ? EXP_W'(1 - SP_BIAS)
              : $signed({5'b00000, operand[30:23]}) - EXP_W'(SP_BIAS);
    end
  end

  // alignment to integer + guard/sticky
  logic [XLEN-1:0] intPart;
  logic            rBit, sBit, hugeExp;
  logic [FX_W-1:0] fx;

  always_comb begin
    intPart = '0;
    rBit    = 1'b0;
    sBit    = 1'b0;
    hugeExp = 1'b0;
    fx      = '0;
    if (expUnb > EXP_W'(XLEN - 1)) begin
      hugeExp = 1'b1;
    end else if (expUnb >= EXP_W'(DP_FRAC_W)) begin
      intPart = {{(XLEN-MANT_W){1'b0}}, mant} << 6'(expUnb - EXP_W'(DP_FRAC_W));
    end else if (expUnb >= EXP_W'(DP_FRAC_W - XLEN + 1)) begin
      fx      = {mant, {XLEN{1'b0}}} >> 7'(EXP_W'(DP_FRAC_W) - expUnb);
      intPart = {{(XLEN-MANT_W){1'b0}}, fx[FX_W-1:XLEN]};
      rBit    = fx[XLEN-1];
      sBit    = |fx[XLEN-2:0];
    end else begin
      sBit = |mant;
    end
  end

  // rounding increment
  logic roundUp;
  always_comb begin
    case (rndSel_e'(rndMode))
      RM_ZERO:     roundUp = 1'b0;
      RM_DOWN:     roundUp = (rBit | sBit) & srcSign;
      RM_UP:       roundUp = (rBit | sBit) & !srcSign;
      RM_NEAR_MAX: roundUp = rBit;
      default:     roundUp = rBit & (sBit | intPart[0]);
    endcase
  end

  logic [MAG_W-1:0] mag, posLim, negLim;
  logic             isSigned, isNarrow, outOfRange;
  logic [XLEN-1:0]  wideRes, nextRes;
  logic [FLAG_W-1:0] nextFlags;

  always_comb begin
    mag      = {1'b0, intPart} + MAG_W'(roundUp);
    isSigned = !variant[0];
    isNarrow = !variant[1];
    case (dstSel_e'(variant))
      DST_S32: begin posLim = (MAG_W'(1) << (HALF_W-1)) - 1'b1; negLim = MAG_W'(1) << (HALF_W-1); end
      DST_U32: begin posLim = (MAG_W'(1) << HALF_W) - 1'b1;     negLim = '0; end
      DST_S64: begin posLim = (MAG_W'(1) << (XLEN-1)) - 1'b1;   negLim = MAG_W'(1) << (XLEN-1); end
      default: begin posLim = (MAG_W'(1) << XLEN) - 1'b1;       negLim = '0; end
    endcase
    outOfRange = hugeExp || srcInf || (srcSign ? (mag > negLim) : (mag > posLim));

    nextFlags = '0;
    if (srcNan) begin
      nextFlags[FLG_NV] = 1'b1;
      wideRes = isSigned ? posLim[XLEN-1:0] : '1;
    end else if (outOfRange) begin
      nextFlags[FLG_NV] = 1'b1;
      if (isSigned) wideRes = srcSign ? negLim[XLEN-1:0] : posLim[XLEN-1:0];
      else          wideRes = srcSign ? '0 : '1;
    end else begin
      nextFlags[FLG_NX] = rBit | sBit;
      wideRes = srcSign ? (~mag[XLEN-1:0] + 1'b1) : mag[XLEN-1:0];
    end
    nextRes = isNarrow ? {{HALF_W{wideRes[HALF_W-1]}}, wideRes[HALF_W-1:0]} : wideRes;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result <= '0;
      flags  <= '0;
    end else if (strobe.capture) begin
      result <= nextRes;
      flags  <= nextFlags;
    end
  end
endmodule

// File: rtl/fp2int_cvt.sv
module fp2int_cvt
  import f2i_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [63:0] operand,
  input  logic        isDouble,
  input  logic [1:0]  variant,
  input  logic [2:0]  rndMode,
  output logic        outValid,
  output logic [63:0] result,
  output logic [4:0]  flags
);
  cvtStrobe_t strobe;

  f2i_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  f2i_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .operand  (operand),
    .isDouble (isDouble),
    .variant  (variant),
    .rndMode  (rndMode),
    .result   (result),
    .flags    (flags)
  );
endmodule

// File: rtl/f2i_checker.sv
module f2i_checker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [63:0] operand,
  input logic        isDouble,
  input logic [1:0]  variant,
  input logic        outValid,
  input logic [63:0] result,
  input logic [4:0]  flags
);
  logic opNan, opNeg;
  always_comb begin
    if (isDouble) begin
      opNan = (&operand[62:52]) && (|operand[51:0]);
      opNeg = operand[63];
    end else begin
      opNan = (&operand[30:23]) && (|operand[22:0]);
      opNeg = operand[31];
    end
  end

  // R1
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R1
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  // R10
  flags_unused_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (flags[3:1] == 3'b000));
  // R6
  nv_nx_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !(flags[4] && flags[0]));
  // R9
  narrow_sext_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !variant[1]) |=> (result[63:32] == {32{result[31]}}));
  // R5
  nan_invalid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opNan) |=> (flags == 5'h10));
  // R7
  uns_neg_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && variant[0] && opNeg && !opNan) |=> (result == 64'd0));
endmodule

bind fp2int_cvt f2i_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .operand  (operand),
  .isDouble (isDouble),
  .variant  (variant),
  .outValid (outValid),
  .result   (result),
  .flags    (flags)
);

// File: tb/tb_fp2int_cvt.sv
module tb_fp2int_cvt;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [63:0] operand;
  logic        isDouble;
  logic [1:0]  variant;
  logic [2:0]  rndMode;
  logic        outValid;
  logic [63:0] result;
  logic [4:0]  flags;

  fp2int_cvt dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .operand(operand),
    .isDouble(isDouble), .variant(variant), .rndMode(rndMode),
    .outValid(outValid), .result(result), .flags(flags)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  logic checking = 1'b0;

  // expectation attached to the currently driven vector
  logic [63:0] expRes;
  logic [4:0]  expFlags;
  string       expTag;

  // reference pipeline: one-entry queue of expectations
  logic        capV;
  logic [63:0] capR;
  logic [4:0]  capF;
  string       capT;

  localparam logic [4:0] NX = 5'h01;
  localparam logic [4:0] NV = 5'h10;

  always @(posedge clk) begin
    capV = inValid && rstN;
    capR = expRes;
    capF = expFlags;
    capT = expTag;
    #(CLK_PERIOD/4);
    if (checking) begin
      nChecks++;
      if (outValid !== capV) begin
        nFails++;
        $display("FAIL R1 outValid: got %b expected %b", outValid, capV);
      end else if (capV && (result !== capR || flags !== capF)) begin
        nFails++;
        $display("FAIL %s: result %h flags %h, expected %h flags %h",
                 capT, result, flags, capR, capF);
      end
    end
  end

  task automatic vec(input logic [63:0] op, input logic dbl, input logic [1:0] v,
                     input logic [2:0] rm, input logic [63:0] r, input logic [4:0] f,
                     input string t);
    @(negedge clk);
    operand  = op;
    isDouble = dbl;
    variant  = v;
    rndMode  = rm;
    expRes   = r;
    expFlags = f;
    expTag   = t;
    inValid  = 1'b1;
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
    operand = 64'hFFF8_0000_0000_0001;
    expTag  = "R1 idle";
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; operand = '0; isDouble = 1'b0;
    variant = 2'd0; rndMode = 3'd0; expRes = '0; expFlags = '0; expTag = "";
    repeat (3) @(negedge clk);
    nChecks++;
    if (outValid !== 1'b0 || result !== 64'd0 || flags !== 5'd0) begin
      nFails++;
      $display("FAIL R1 reset: got %b %h %h expected 0 0 0", outValid, result, flags);
    end
    rstN = 1'b1;
    checking = 1'b1;

    // R3 rounding modes on +2.5 and -2.5 (binary64), signed 32
    vec(64'h4004_0000_0000_0000, 1, 0, 0, 64'd2, NX, "R3 rne 2.5");
    vec(64'h4004_0000_0000_0000, 1, 0, 1, 64'd2, NX, "R3 rtz 2.5");
    vec(64'h4004_0000_0000_0000, 1, 0, 2, 64'd2, NX, "R3 rdn 2.5");
    vec(64'h4004_0000_0000_0000, 1, 0, 3, 64'd3, NX, "R3 rup 2.5");
    vec(64'h4004_0000_0000_0000, 1, 0, 4, 64'd3, NX, "R3 rmm 2.5");
    vec(64'h4004_0000_0000_0000, 1, 0, 6, 64'd2, NX, "R3 reserved 2.5");
    vec(64'hC004_0000_0000_0000, 1, 0, 2, 64'hFFFF_FFFF_FFFF_FFFD, NX, "R3 rdn -2.5");
    vec(64'hC004_0000_0000_0000, 1, 0, 3, 64'hFFFF_FFFF_FFFF_FFFE, NX, "R3 rup -2.5");
    idle();
    // R2 binary32 source with garbage upper half
    vec(64'hDEAD_BEEF_4060_0000, 0, 0, 0, 64'd4, NX, "R2 single 3.5");
    vec(64'h0000_0000_3F80_0000, 0, 2, 0, 64'd1, 5'h00, "R4 single 1.0 exact");
    vec(64'h0000_0000_BFC0_0000, 0, 2, 0, 64'hFFFF_FFFF_FFFF_FFFE, NX, "R2 single -1.5");
    vec(64'h0000_0000_0000_0000, 1, 0, 0, 64'd0, 5'h00, "R4 zero");
    vec(64'h0000_0000_0000_0001, 1, 2, 3, 64'd1, NX, "R4 subnormal rup");
    // R5 NaN
    vec(64'h7FF8_0000_0000_0000, 1, 0, 0, 64'h0000_0000_7FFF_FFFF, NV, "R5 nan s32");
    vec(64'h7FF8_0000_0000_0000, 1, 2, 0, 64'h7FFF_FFFF_FFFF_FFFF, NV, "R5 nan s64");
    vec(64'h7FF8_0000_0000_0000, 1, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, NV, "R5 nan u32");
    vec(64'h0000_0000_7FC0_0000, 0, 2, 0, 64'h7FFF_FFFF_FFFF_FFFF, NV, "R5 single nan s64");
    // R6 signed saturation
    vec(64'h7FF0_0000_0000_0000, 1, 0, 0, 64'h0000_0000_7FFF_FFFF, NV, "R6 +inf s32");
    vec(64'hFFF0_0000_0000_0000, 1, 2, 0, 64'h8000_0000_0000_0000, NV, "R6 -inf s64");
    vec(64'h41E6_5A0B_C000_0000, 1, 0, 0, 64'h0000_0000_7FFF_FFFF, NV, "R6 3e9 s32");
    vec(64'h43E0_0000_0000_0000, 1, 2, 0, 64'h7FFF_FFFF_FFFF_FFFF, NV, "R6 2^63 s64");
    vec(64'hC3E0_0000_0000_0000, 1, 2, 0, 64'h8000_0000_0000_0000, 5'h00, "R6 -2^63 s64 fits");
    vec(64'hC1E0_0000_0000_0000, 1, 0, 0, 64'hFFFF_FFFF_8000_0000, 5'h00, "R6 -2^31 s32 fits");
    vec(64'hC1E0_0000_0020_0000, 1, 0, 0, 64'hFFFF_FFFF_8000_0000, NV, "R6 -2^31-1 s32");
    idle();
    // R7 unsigned negative
    vec(64'hBFD0_0000_0000_0000, 1, 1, 0, 64'd0, NX, "R7 -0.25 rne u32");
    vec(64'hBFD0_0000_0000_0000, 1, 1, 2, 64'd0, NV, "R7 -0.25 rdn u32");
    vec(64'hBFE0_0000_0000_0000, 1, 1, 4, 64'd0, NV, "R7 -0.5 rmm u32");
    vec(64'hBFE0_0000_0000_0000, 1, 3, 0, 64'd0, NX, "R7 -0.5 rne u64");
    vec(64'hBFF0_0000_0000_0000, 1, 3, 0, 64'd0, NV, "R7 -1.0 u64");
    vec(64'h8000_0000_0000_0000, 1, 1, 0, 64'd0, 5'h00, "R7 -0.0 u32");
    // R8 unsigned overflow and R9 sign extension
    vec(64'h41F0_0000_0000_0000, 1, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, NV, "R8 2^32 u32");
    vec(64'h43F0_0000_0000_0000, 1, 3, 0, 64'hFFFF_FFFF_FFFF_FFFF, NV, "R8 2^64 u64");
    vec(64'h41EF_FFFF_FFF0_0000, 1, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, NV, "R8 round carry u32");
    vec(64'h41EF_FFFF_FFF0_0000, 1, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, NX, "R8 rtz fits u32");
    vec(64'h43EF_FFFF_FFFF_FFFF, 1, 3, 0, 64'hFFFF_FFFF_FFFF_F800, 5'h00, "R8 max fit u64");
    vec(64'h41E6_5A0B_C000_0000, 1, 1, 0, 64'hFFFF_FFFF_B2D0_5E00, 5'h00, "R9 3e9 u32 sext");
    vec(64'h41E6_5A0B_C000_0000, 1, 2, 0, 64'h0000_0000_B2D0_5E00, 5'h00, "R9 3e9 s64");
    idle();
    idle();
    @(negedge clk);
    checking = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule